// File: doc/BRIEF.md
# Multicart Outer-Bank Address Composer

This block forms the upper ROM address lines of a cartridge that packs many games behind one bank-switching controller. It takes the controller's selected 8 KiB program bank and 1 KiB pattern bank for the current access, together with four outer configuration bytes. From these it drives program address lines A24..A13 and pattern address lines A17..A10. The lines above the controller's reach always come from the outer bytes. For program lines A20..A17 and pattern line A17, a per-line switch picks either the controller's bit or a literal bit held in the outer bytes. The switches do not share one polarity.

Two options act on top of that selection. The first is a fixed-window option: it ignores the controller's low bank bits and maps a plain 16 KiB or 32 KiB program window and an 8 KiB pattern window. The second is an alternate option: it replaces the controller's two fixed top program banks with bank 0, and it reshapes how the 2 KiB pattern banks are split. The block is purely combinational. Its outputs follow its inputs within the same cycle.

Top module: `mc_addr_compose`

## Requirements
- R1: Program lines A24, A23, A22, A21 (prg_hi[11:8]) always equal cfg0[5], cfg0[4], cfg1[3], cfg1[2].
- R2: Program line A20 (prg_hi[7]) takes the controller's bank bit 7 when cfg1[7]=1, and otherwise takes cfg1[4].
- R3: Program line A19 (prg_hi[6]) takes the controller's bank bit 6 when cfg1[5]=1, and otherwise takes cfg0[2].
- R4: Program line A18 (prg_hi[5]) takes the controller's bank bit 5 when cfg1[6]=0, and otherwise takes cfg0[1]. Program line A17 (prg_hi[4]) takes the controller's bank bit 4 when cfg0[6]=0, and otherwise takes cfg0[0].
- R5: Pattern line A17 (chr_hi[7]) takes the controller's pattern bank bit 7 when cfg0[7]=0, and otherwise takes cfg0[3].
- R6: When cfg3[4]=0, prg_hi[3:0] equals the controller's program bank bits 3:0 and chr_hi[6:0] equals the controller's pattern bank bits 6:0.
- R7: When cfg3[4]=1 (fixed window), prg_hi[3:2] equals cfg3[3:2], prg_hi[0] equals CPU A13, and chr_hi[6:0] equals {cfg2[3:0], PPU A12..A10}.
- R8: In fixed window, prg_hi[1] (A14) follows CPU A14 when cfg1[1]=1 (32 KiB window), and equals cfg3[1] when cfg1[1]=0 (16 KiB window).
- R9: When cfg3[6]=1 (alternate), the program arrangement is normal (prg_inv=0) and CPU A14=1, every program line that comes from the controller reads 0.
- R10: When cfg3[6]=1 and prg_inv=1, the program output is the same as with cfg3[6]=0.
- R11: When cfg3[6]=1, the access is in a 2 KiB pattern bank and PPU A10=1, every pattern line that comes from the controller reads 0.
- R12: When cfg3[6]=1, the access is in a 2 KiB pattern bank and PPU A10=0, pattern line A10 equals chr_raw_lsb instead of the controller's bank bit 0.
- R13: The per-line switches of R2..R5 still apply while the fixed window is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_a14_13 | input | 2 | CPU address bits 14:13 of the current program access |
| ppu_a12_10 | input | 3 | PPU address bits 12:10 of the current pattern access |
| ctl_prg_bank | input | 8 | Controller's selected 8 KiB program bank (A20..A13) |
| prg_inv | input | 1 | Controller program arrangement, 1 = inverted |
| ctl_chr_bank | input | 8 | Controller's selected 1 KiB pattern bank (A17..A10) |
| chr_in_2k | input | 1 | Current pattern access lies in a 2 KiB bank |
| chr_raw_lsb | input | 1 | Unmodified bit 0 of that 2 KiB bank register |
| cfg0 | input | 8 | Outer configuration byte 0 |
| cfg1 | input | 8 | Outer configuration byte 1 |
| cfg2 | input | 8 | Outer configuration byte 2 |
| cfg3 | input | 8 | Outer configuration byte 3 |
| prg_hi | output | 12 | Program address lines A24..A13 |
| chr_hi | output | 8 | Pattern address lines A17..A10 |

## Verification
There is no register between any input and any output, so every result is due in the same cycle as the stimulus that causes it. The bench changes inputs just after a rising clock edge and reads the outputs at the following falling edge. By that point the combinational paths have settled, and no read depends on the order of events at an edge. Each scenario sets the outer bytes and the controller values together, then compares against values worked out by hand from the requirements.

// File: rtl/mc_compose_pkg.sv
package mc_compose_pkg;

  localparam int CFG_W      = 8;
  localparam int PRG_BANK_W = 8;
  localparam int CHR_BANK_W = 8;
  localparam int SEL_W      = 4;                  // switchable program lines A20..A17
  localparam int TOP_W      = 4;                  // always-literal lines A24..A21
  localparam int LOW_W      = PRG_BANK_W - SEL_W; // program lines A16..A13
  localparam int PRG_OUT_W  = TOP_W + PRG_BANK_W;
  localparam int CHR_LOW_W  = CHR_BANK_W - 1;     // pattern lines A16..A10
  localparam int PPU_W      = 3;
  localparam int FIX_CHR_W  = CHR_LOW_W - PPU_W;

  typedef struct packed {
    logic [TOP_W-1:0]     prg_top;     // A24..A21
    logic [SEL_W-1:0]     prg_lit;     // literal A20..A17
    logic [SEL_W-1:0]     prg_use_ctl; // 1 = controller drives that line
    logic                 chr_lit;
    logic                 chr_use_ctl;
    logic                 fixed_win;
    logic                 alt_mode;
    logic                 win32k;
    logic [2:0]           fix_prg;     // A16, A15, A14 in fixed window
    logic [FIX_CHR_W-1:0] fix_chr;     // A16..A13 in fixed window
  } outer_cfg_t;

  function automatic outer_cfg_t decode_outer(input logic [CFG_W-1:0] c0,
                                              input logic [CFG_W-1:0] c1,
                                              input logic [CFG_W-1:0] c2,
                                              input logic [CFG_W-1:0] c3);
    outer_cfg_t d;
    d.prg_top     = {c0[5], c0[4], c1[3], c1[2]};
    d.prg_lit     = {c1[4], c0[2], c0[1], c0[0]};
    d.prg_use_ctl = {c1[7], c1[5], ~c1[6], ~c0[6]};
    d.chr_lit     = c0[3];
    d.chr_use_ctl = ~c0[7];
    d.fixed_win   = c3[4];
    d.alt_mode    = c3[6];
    d.win32k      = c1[1];
    d.fix_prg     = c3[3:1];
    d.fix_chr     = c2[FIX_CHR_W-1:0];
    return d;
  endfunction

endpackage

// File: rtl/mc_cfg_decode.sv
module mc_cfg_decode
  import mc_compose_pkg::*;
(
  input  logic [CFG_W-1:0] cfg0,
  input  logic [CFG_W-1:0] cfg1,
  input  logic [CFG_W-1:0] cfg2,
  input  logic [CFG_W-1:0] cfg3,
  output outer_cfg_t       dec
);
  always_comb begin
    dec = decode_outer(cfg0, cfg1, cfg2, cfg3);
  end
endmodule

// File: rtl/mc_src_mux.sv
module mc_src_mux #(
  parameter int W = 4
) (
  input  logic [W-1:0] use_ctl,
  input  logic [W-1:0] ctl_bits,
  input  logic [W-1:0] lit_bits,
  output logic [W-1:0] out_bits
);
  for (genvar i = 0; i < W; i++) begin : g_line
    assign out_bits[i] = use_ctl[i] ? ctl_bits[i] : lit_bits[i];
  end
endmodule

// File: rtl/mc_prg_path.sv
module mc_prg_path
  import mc_compose_pkg::*;
(
  input  outer_cfg_t            dec,
  input  logic [PRG_BANK_W-1:0] ctl_prg_bank,
  input  logic                  prg_inv,
  input  logic [1:0]            cpu_a14_13,
  output logic [PRG_OUT_W-1:0]  prg_hi
);
  logic                  force_zero;
  logic [PRG_BANK_W-1:0] eff_bank;
  logic [SEL_W-1:0]      mid;
  logic [LOW_W-1:0]      low;

  // Alternate option: the two fixed upper windows collapse onto bank 0
  assign force_zero = dec.alt_mode & ~prg_inv & cpu_a14_13[1];
  assign eff_bank   = force_zero ? '0 : ctl_prg_bank;

  mc_src_mux #(.W(SEL_W)) u_mid (
    .use_ctl  (dec.prg_use_ctl),
    .ctl_bits (eff_bank[PRG_BANK_W-1:LOW_W]),
    .lit_bits (dec.prg_lit),
    .out_bits (mid)
  );

  always_comb begin
    if (dec.fixed_win) begin
      low = {dec.fix_prg[2:1],
             dec.win32k ? cpu_a14_13[1] : dec.fix_prg[0],
             cpu_a14_13[0]};
    end else begin
      low = eff_bank[LOW_W-1:0];
    end
  end

  assign prg_hi = {dec.prg_top, mid, low};
endmodule

// File: rtl/mc_chr_path.sv
module mc_chr_path
  import mc_compose_pkg::*;
(
  input  outer_cfg_t            dec,
  input  logic [CHR_BANK_W-1:0] ctl_chr_bank,
  input  logic                  chr_in_2k,
  input  logic                  chr_raw_lsb,
  input  logic [PPU_W-1:0]      ppu_a12_10,
  output logic [CHR_BANK_W-1:0] chr_hi
);
  logic [CHR_BANK_W-1:0] eff_bank;
  logic [0:0]            top_bit;
  logic [CHR_LOW_W-1:0]  low;

  always_comb begin
    eff_bank = ctl_chr_bank;
    if (dec.alt_mode && chr_in_2k) begin
      if (ppu_a12_10[0]) eff_bank = '0;
      else               eff_bank = {ctl_chr_bank[CHR_BANK_W-1:1], chr_raw_lsb};
    end
  end

  mc_src_mux #(.W(1)) u_top (
    .use_ctl  (dec.chr_use_ctl),
    .ctl_bits (eff_bank[CHR_BANK_W-1]),
    .lit_bits (dec.chr_lit),
    .out_bits (top_bit)
  );

  always_comb begin
    if (dec.fixed_win) low = {dec.fix_chr, ppu_a12_10};
    else               low = eff_bank[CHR_LOW_W-1:0];
  end

  assign chr_hi = {top_bit, low};
endmodule

// File: rtl/mc_addr_compose.sv
module mc_addr_compose
  import mc_compose_pkg::*;
(
  input  logic [1:0]            cpu_a14_13,
  input  logic [PPU_W-1:0]      ppu_a12_10,
  input  logic [PRG_BANK_W-1:0] ctl_prg_bank,
  input  logic                  prg_inv,
  input  logic [CHR_BANK_W-1:0] ctl_chr_bank,
  input  logic                  chr_in_2k,
  input  logic                  chr_raw_lsb,
  input  logic [CFG_W-1:0]      cfg0,
  input  logic [CFG_W-1:0]      cfg1,
  input  logic [CFG_W-1:0]      cfg2,
  input  logic [CFG_W-1:0]      cfg3,
  output logic [PRG_OUT_W-1:0]  prg_hi,
  output logic [CHR_BANK_W-1:0] chr_hi
);
  outer_cfg_t dec;

  mc_cfg_decode u_dec (
    .cfg0 (cfg0), .cfg1 (cfg1), .cfg2 (cfg2), .cfg3 (cfg3), .dec (dec)
  );

  mc_prg_path u_prg (
    .dec          (dec),
    .ctl_prg_bank (ctl_prg_bank),
    .prg_inv      (prg_inv),
    .cpu_a14_13   (cpu_a14_13),
    .prg_hi       (prg_hi)
  );

  mc_chr_path u_chr (
    .dec          (dec),
    .ctl_chr_bank (ctl_chr_bank),
    .chr_in_2k    (chr_in_2k),
    .chr_raw_lsb  (chr_raw_lsb),
    .ppu_a12_10   (ppu_a12_10),
    .chr_hi       (chr_hi)
  );
endmodule

// File: rtl/mc_addr_compose_chk.sv
module mc_addr_compose_chk (
  input logic [1:0]  cpu_a14_13,
  input logic [2:0]  ppu_a12_10,
  input logic [7:0]  ctl_prg_bank,
  input logic        prg_inv,
  input logic [7:0]  cfg0,
  input logic [7:0]  cfg1,
  input logic [7:0]  cfg2,
  input logic [7:0]  cfg3,
  input logic [11:0] prg_hi,
  input logic [7:0]  chr_hi
);
  always_comb begin
    if (!$isunknown({cfg0, cfg1, cfg2, cfg3, cpu_a14_13, ppu_a12_10,
                     ctl_prg_bank, prg_inv})) begin
      // R1
      top_lines_chk: assert (prg_hi[11:8] == {cfg0[5:4], cfg1[3:2]})
        else $error("top lines wrong");
      // R2
      a20_literal_chk: assert (cfg1[7] || prg_hi[7] == cfg1[4])
        else $error("A20 literal wrong");
      // R3
      a19_literal_chk: assert (cfg1[5] || prg_hi[6] == cfg0[2])
        else $error("A19 literal wrong");
      // R4
      a18_literal_chk: assert (!cfg1[6] || prg_hi[5] == cfg0[1])
        else $error("A18 literal wrong");
      // R4
      a17_literal_chk: assert (!cfg0[6] || prg_hi[4] == cfg0[0])
        else $error("A17 literal wrong");
      // R5
      chr_a17_literal_chk: assert (!cfg0[7] || chr_hi[7] == cfg0[3])
        else $error("pattern A17 literal wrong");
      // R7
      fixed_window_chk: assert (!cfg3[4] ||
          (prg_hi[3:2] == cfg3[3:2] && prg_hi[0] == cpu_a14_13[0] &&
           chr_hi[6:0] == {cfg2[3:0], ppu_a12_10}))
        else $error("fixed window lines wrong");
      // R8
      window_32k_chk: assert (!(cfg3[4] && cfg1[1]) || prg_hi[1] == cpu_a14_13[1])
        else $error("32K window A14 wrong");
      // R10
      alt_inverted_chk: assert (!(cfg3[6] && prg_inv && !cfg3[4]) ||
          prg_hi[3:0] == ctl_prg_bank[3:0])
        else $error("alternate touched inverted arrangement");
    end
  end
endmodule

bind mc_addr_compose mc_addr_compose_chk u_chk (
  .cpu_a14_13   (cpu_a14_13),
  .ppu_a12_10   (ppu_a12_10),
  .ctl_prg_bank (ctl_prg_bank),
  .prg_inv      (prg_inv),
  .cfg0         (cfg0),
  .cfg1         (cfg1),
  .cfg2         (cfg2),
  .cfg3         (cfg3),
  .prg_hi       (prg_hi),
  .chr_hi       (chr_hi)
);

// File: tb/tb_mc_addr_compose.sv
module tb_mc_addr_compose;
  logic        clk;
  logic [1:0]  cpu_a14_13;
  logic [2:0]  ppu_a12_10;
  logic [7:0]  ctl_prg_bank;
  logic        prg_inv;
  logic [7:0]  ctl_chr_bank;
  logic        chr_in_2k;
  logic        chr_raw_lsb;
  logic [7:0]  cfg0, cfg1, cfg2, cfg3;
  logic [11:0] prg_hi;
  logic [7:0]  chr_hi;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  mc_addr_compose dut (
    .cpu_a14_13 (cpu_a14_13), .ppu_a12_10 (ppu_a12_10),
    .ctl_prg_bank (ctl_prg_bank), .prg_inv (prg_inv),
    .ctl_chr_bank (ctl_chr_bank), .chr_in_2k (chr_in_2k),
    .chr_raw_lsb (chr_raw_lsb),
    .cfg0 (cfg0), .cfg1 (cfg1), .cfg2 (cfg2), .cfg3 (cfg3),
    .prg_hi (prg_hi), .chr_hi (chr_hi)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  task automatic chk(input string tag, input logic [11:0] got, input logic [11:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Inputs change right after a rising edge; results are read at the falling edge.
  task automatic apply(input logic [7:0] c0, input logic [7:0] c1,
                       input logic [7:0] c2, input logic [7:0] c3,
                       input logic [7:0] pb, input logic inv, input logic [1:0] ca,
                       input logic [7:0] cb, input logic in2k, input logic lsb,
                       input logic [2:0] pa);
    @(posedge clk);
    cfg0 = c0; cfg1 = c1; cfg2 = c2; cfg3 = c3;
    ctl_prg_bank = pb; prg_inv = inv; cpu_a14_13 = ca;
    ctl_chr_bank = cb; chr_in_2k = in2k; chr_raw_lsb = lsb; ppu_a12_10 = pa;
    @(negedge clk);
  endtask

  task automatic t_idle;
    apply(8'h00, 8'h00, 8'h00, 8'h00, 8'h5A, 0, 2'b10, 8'h3C, 0, 0, 3'b000);
    chk("R6 prg passthrough", prg_hi, 12'h01A);
    chk("R6 chr passthrough", {4'h0, chr_hi}, 12'h03C);
  endtask

  task automatic t_top;
    apply(8'h30, 8'h0C, 8'h00, 8'h00, 8'h00, 0, 2'b00, 8'h00, 0, 0, 3'b000);
    chk("R1 all top set", prg_hi, 12'hF00);
    apply(8'h10, 8'h04, 8'h00, 8'h00, 8'h00, 0, 2'b00, 8'h00, 0, 0, 3'b000);
    chk("R1 top pattern", prg_hi, 12'h500);
  endtask

  task automatic t_a20_a19;
    apply(8'h00, 8'hA0, 8'h00, 8'h00, 8'hC0, 0, 2'b00, 8'h00, 0, 0, 3'b000);
    chk("R2 R3 from controller", prg_hi, 12'h0C0);
    apply(8'h04, 8'h10, 8'h00, 8'h00, 8'h30, 0, 2'b00, 8'h00, 0, 0, 3'b000);
    chk("R2 R3 literal ones", prg_hi, 12'h0F0);
    apply(8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 0, 2'b00, 8'h00, 0, 0, 3'b000);
    chk("R2 R3 literal zeros", prg_hi, 12'h03F);
  endtask

  task automatic t_a18_a17;
    apply(8'h43, 8'h40, 8'h00, 8'h00, 8'h00, 0, 2'b00, 8'h00, 0, 0, 3'b000);
    chk("R4 literal ones", prg_hi, 12'h030);
    apply(8'h40, 8'h40, 8'h00, 8'h00, 8'hFF, 0, 2'b00, 8'h00, 0, 0, 3'b000);
    chk("R4 literal zeros", prg_hi, 12'h00F);
  endtask

  task automatic t_chr_top;
    apply(8'h88, 8'h00, 8'h00, 8'h00, 8'h00, 0, 2'b00, 8'h00, 0, 0, 3'b000);
    chk("R5 literal one", {4'h0, chr_hi}, 12'h080);
    apply(8'h80, 8'h00, 8'h00, 8'h00, 8'h00, 0, 2'b00, 8'hFF, 0, 0, 3'b000);
    chk("R5 literal zero", {4'h0, chr_hi}, 12'h07F);
    apply(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 0, 2'b00, 8'h80, 0, 0, 3'b000);
    chk("R5 from controller", {4'h0, chr_hi}, 12'h080);
  endtask

  task automatic t_fixed;
    apply(8'h00, 8'h00, 8'h0A, 8'h1C, 8'h00, 0, 2'b11, 8'h00, 0, 0, 3'b101);
    chk("R7 R8 16K prg", prg_hi, 12'h00D);
    chk("R7 chr window", {4'h0, chr_hi}, 12'h055);
    apply(8'h00, 8'h02, 8'h0A, 8'h1C, 8'h00, 0, 2'b10, 8'h00, 0, 0, 3'b101);
    chk("R8 32K A14 high", prg_hi, 12'h00E);
    apply(8'h00, 8'h00, 8'h00, 8'h12, 8'h00, 0, 2'b00, 8'h00, 0, 0, 3'b000);
    chk("R8 16K uses cfg3 bit1", prg_hi, 12'h002);
    apply(8'h00, 8'h02, 8'h00, 8'h12, 8'h00, 0, 2'b00, 8'h00, 0, 0, 3'b000);
    chk("R8 32K ignores cfg3 bit1", prg_hi, 12'h000);
  endtask

  task automatic t_fixed_masks;
    apply(8'h88, 8'hA0, 8'h00, 8'h10, 8'hF5, 0, 2'b00, 8'h00, 0, 0, 3'b000);
    chk("R13 prg switches in window", prg_hi, 12'h0F0);
    chk("R13 chr switch in window", {4'h0, chr_hi}, 12'h080);
  endtask

  task automatic t_alt_prg;
    apply(8'h00, 8'hA0, 8'h00, 8'h40, 8'hFE, 0, 2'b10, 8'h00, 0, 0, 3'b000);
    chk("R9 upper half to bank 0", prg_hi, 12'h000);
    apply(8'h00, 8'hA0, 8'h00, 8'h40, 8'hFE, 0, 2'b00, 8'h00, 0, 0, 3'b000);
    chk("R9 lower half untouched", prg_hi, 12'h0FE);
    apply(8'h00, 8'hA0, 8'h00, 8'h00, 8'hFE, 0, 2'b10, 8'h00, 0, 0, 3'b000);
    chk("R9 off keeps bank", prg_hi, 12'h0FE);
  endtask

  task automatic t_alt_inv;
    apply(8'h00, 8'hA0, 8'h00, 8'h40, 8'hFF, 1, 2'b11, 8'h00, 0, 0, 3'b000);
    chk("R10 inverted unaffected", prg_hi, 12'h0FF);
  endtask

  task automatic t_alt_chr;
    apply(8'h00, 8'h00, 8'h00, 8'h40, 8'h00, 0, 2'b00, 8'h7F, 1, 0, 3'b001);
    chk("R11 upper 1K to bank 0", {4'h0, chr_hi}, 12'h000);
    apply(8'h88, 8'h00, 8'h00, 8'h40, 8'h00, 0, 2'b00, 8'h7F, 1, 0, 3'b001);
    chk("R11 with literal A17", {4'h0, chr_hi}, 12'h080);
    apply(8'h00, 8'h00, 8'h00, 8'h40, 8'h00, 0, 2'b00, 8'h46, 1, 1, 3'b000);
    chk("R12 raw lsb used", {4'h0, chr_hi}, 12'h047);
    apply(8'h00, 8'h00, 8'h00, 8'h40, 8'h00, 0, 2'b00, 8'h7F, 0, 0, 3'b001);
    chk("R11 1K bank untouched", {4'h0, chr_hi}, 12'h07F);
    apply(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 0, 2'b00, 8'h7F, 1, 0, 3'b001);
    chk("R11 off keeps bank", {4'h0, chr_hi}, 12'h07F);
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_idle();
    t_top();
    t_a20_a19();
    t_a18_a17();
    t_chr_top();
    t_fixed();
    t_fixed_masks();
    t_alt_prg();
    t_alt_inv();
    t_alt_chr();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule